// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave-only serial control port that lets an external microcontroller set up the data-path settings of a receive amplifier. The clock line and the data line of the two-wire bus are oversampled on a fast system clock, and the block recognises START, repeated START and STOP conditions. It answers to one fixed 7-bit device address. Each transaction carries a register address and then exactly one data byte, which is either written or read back.

A small file of eight-bit registers holds the settings. The block decodes them into separate control fields such as output polarity, output mute, swing, de-emphasis, slice adjust and loss-of-signal masking. One extra read-only location shows a 7-bit status input. An external disable pin, together with a lock-enable bit in the control register, can make the block deaf to the serial clock. The data line is open-drain: the block only ever asserts an enable that pulls the line low.

Top module: `cfg_twowire_slave`

## Requirements
- R1: After reset every decoded field is 0 except `swing_code`, which is 2, and `sda_oe` is 0.
- R2: A write addressed to device 0x44 with R/W bit 0 gets an ACK (line held low) for the address byte, the register-address byte and the data byte, and the data byte is stored in the addressed register.
- R3: A transaction whose 7-bit address is not 0x44 gets no ACK on any of its bytes and changes no register.
- R4: A register-address write phase followed by a repeated START and address 0x44 with R/W bit 1 is acknowledged, and the block then returns the register's eight bits, most significant bit first.
- R5: A transaction stores only one data byte. Any further write byte gets a NACK and is discarded, and the register pointer does not advance.
- R6: Address 0x0F reads as bit 7 = 0 and bits 6:0 = `los_status_i`. A write to 0x0F is acknowledged and has no effect.
- R7: Writes to 0x0E and to 0x10..0xFF are acknowledged and discarded. Reads from those addresses return 0x00.
- R8: `sda_oe` changes only while the synchronised clock line is low, except when the lock releases the line.
- R9: A STOP or a START releases the data line and aborts the transfer in progress. A transaction cut off before its data byte is complete writes nothing.
- R10: While control bit 0x00[5] is 1 and `dis_pin_i` is high, the block ignores the bus: it holds the line released, sees no conditions and writes nothing. The byte that sets this lock is stored, but its ACK is cut short, so the master samples a NACK.
- R11: Field map. Register 0x00: bit 5 lock enable, bit 4 invert, bit 3 mute, bit 2 high LOS range, bit 1 offset-cancel off. Register 0x01: slice adjust [7:0]. Register 0x02: bits 5:4 crossing range, bits 3:0 de-emphasis. Register 0x03: bits 2:0 swing. Register 0x07: bit 7 tuning enable, bits 3:2 tuning code, bit 0 bias boost. Register 0x0B: bit 7 programmed LOS level, bits 6:0 level code. Registers 0x0C and 0x0D: bit 7 enables falling or rising mask, bits 6:0 mask time. Each field follows its register one cycle after the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the serial clock line |
| sda_i | input | 1 | Level of the serial data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| dis_pin_i | input | 1 | External disable pin, used for the lock |
| los_status_i | input | 7 | Status value shown at address 0x0F |
| ser_lock_en | output | 1 | Lock enable bit |
| out_invert | output | 1 | Output polarity inversion |
| out_mute | output | 1 | Output stage disable |
| los_rng_hi | output | 1 | High loss-of-signal threshold range |
| offs_cancel_off | output | 1 | Offset cancellation disabled |
| slice_adj | output | 8 | Input threshold adjust code |
| xpt_range | output | 2 | Crossing-point adjust range |
| deemph_code | output | 4 | Output de-emphasis code |
| swing_code | output | 3 | Output amplitude code |
| rx_tune_en | output | 1 | Use the receiver tuning fields |
| rx_tune | output | 2 | Receiver tuning code |
| in_bias_boost | output | 1 | Extra input stage bias |
| los_lvl_prog | output | 1 | Use programmed LOS level |
| los_lvl_code | output | 7 | Programmed LOS level |
| fmask_en | output | 1 | Falling-edge LOS mask enable |
| fmask_time | output | 7 | Falling-edge mask time |
| rmask_en | output | 1 | Rising-edge LOS mask enable |
| rmask_time | output | 7 | Rising-edge mask time |

## Verification
Two events can land in the same few cycles: a data byte commits to register 0x00, and the lock that this byte creates takes hold while the block is still driving that byte's ACK. The bench holds the disable pin high and writes 0x20 to 0x00. It expects the address and register bytes to be acknowledged, the data byte to read as a NACK, and the lock-enable field to be set. A following transaction must then be ignored completely. A behavioural model of the register contents is compared with every decoded field on every idle clock. A monitor flags any change of `sda_oe` while the master holds the clock line high.

// File: rtl/cfg_twowire_pkg.sv
package cfg_twowire_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    // register indices whose positions the decode depends on
    localparam int REG_CTRL  = 0;
    localparam int REG_SLICE = 1;
    localparam int REG_XPDE  = 2;
    localparam int REG_SWING = 3;
    localparam int REG_TUNE  = 7;
    localparam int REG_LOSL  = 11;
    localparam int REG_FMASK = 12;
    localparam int REG_RMASK = 13;

    localparam logic [7:0] SWING_RST = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDAT,
        ST_RDAT,
        ST_MACK,
        ST_ACK,
        ST_WAIT
    } bus_state_e;

    typedef struct packed {
        bus_state_e       st;
        bus_state_e       ack_next;
        logic [7:0]       shift;
        logic [CNT_W-1:0] bitcnt;
        logic [7:0]       ptr;
        logic             sda_oe;
        logic             wr_en;
        logic [7:0]       wr_data;
        logic             scl_p;
        logic             sda_p;
    } eng_state_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d[0] = d;
        end else begin : g_chain
            always_comb begin
                chain_d[0] = d;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_bus_engine.sv
module cfg_bus_engine
    import cfg_twowire_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       lock,
    input  logic [7:0] rdata,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sda_oe,
    output logic       start_evt,
    output logic       stop_evt
);

    localparam eng_state_t ENG_RST = '{
        st:       ST_IDLE,
        ack_next: ST_IDLE,
        shift:    '0,
        bitcnt:   '0,
        ptr:      '0,
        sda_oe:   1'b0,
        wr_en:    1'b0,
        wr_data:  '0,
        scl_p:    1'b1,
        sda_p:    1'b1
    };
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    eng_state_t q, n;
    logic scl_rise, scl_fall;

    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign start_evt = ~lock & scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_evt  = ~lock & scl_s & q.scl_p & ~q.sda_p & sda_s;

    always_comb begin
        n       = q;
        n.wr_en = 1'b0;
        n.scl_p = scl_s;
        n.sda_p = sda_s;

        if (lock) begin
            n.st     = ST_IDLE;
            n.sda_oe = 1'b0;
            n.bitcnt = '0;
        end else if (start_evt) begin
            n.st     = ST_ADDR;
            n.bitcnt = '0;
            n.shift  = '0;
            n.sda_oe = 1'b0;
        end else if (stop_evt) begin
            n.st     = ST_IDLE;
            n.bitcnt = '0;
            n.sda_oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_REG, ST_WDAT: begin
                    if (scl_rise && q.bitcnt < FULL) begin
                        n.shift  = {q.shift[6:0], sda_s};
                        n.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall && q.bitcnt == FULL) begin
                        n.bitcnt = '0;
                        n.st     = ST_ACK;
                        if (q.st == ST_ADDR) begin
                            if (q.shift[7:1] == DEV_ADDR) begin
                                n.sda_oe   = 1'b1;
                                n.ack_next = q.shift[0] ? ST_RDAT : ST_REG;
                            end else begin
                                n.st = ST_WAIT;
                            end
                        end else if (q.st == ST_REG) begin
                            n.sda_oe   = 1'b1;
                            n.ptr      = q.shift;
                            n.ack_next = ST_WDAT;
                        end else begin
                            n.sda_oe   = 1'b1;
                            n.wr_en    = 1'b1;
                            n.wr_data  = q.shift;
                            n.ack_next = ST_WAIT;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.bitcnt = '0;
                        n.st     = q.ack_next;
                        if (q.ack_next == ST_RDAT) begin
                            n.shift  = rdata;
                            n.sda_oe = ~rdata[7];
                        end else begin
                            n.shift  = '0;
                            n.sda_oe = 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        n.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == FULL) begin
                            n.sda_oe = 1'b0;
                            n.bitcnt = '0;
                            n.st     = ST_MACK;
                        end else begin
                            n.shift  = {q.shift[6:0], 1'b0};
                            n.sda_oe = ~q.shift[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        n.st = ST_WAIT;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= ENG_RST;
        end else begin
            q <= n;
        end
    end

    assign ptr     = q.ptr;
    assign wr_en   = q.wr_en;
    assign wr_data = q.wr_data;
    assign sda_oe  = q.sda_oe;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_twowire_pkg::*;
#(
    parameter int         NUM_REGS    = 14,
    parameter logic [7:0] STATUS_ADDR = 8'h0F,
    parameter int         STAT_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            addr,
    input  logic [7:0]            wr_data,
    input  logic [STAT_W-1:0]     status,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam int AW = $clog2(NUM_REGS);

    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];
    logic       in_file;

    assign in_file = int'(addr) < NUM_REGS;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && in_file) begin
            regs_d[addr[AW-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= (i == REG_SWING) ? SWING_RST : 8'h00;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (in_file) begin
            rdata = regs_q[addr[AW-1:0]];
        end else if (addr == STATUS_ADDR) begin
            rdata[STAT_W-1:0] = status;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
            assign regs_flat[g*8 +: 8] = regs_q[g];
        end
    endgenerate

endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave
    import cfg_twowire_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         NUM_REGS    = 14,
    parameter logic [7:0] STATUS_ADDR = 8'h0F,
    parameter int         STAT_W      = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              dis_pin_i,
    input  logic [STAT_W-1:0] los_status_i,
    output logic              ser_lock_en,
    output logic              out_invert,
    output logic              out_mute,
    output logic              los_rng_hi,
    output logic              offs_cancel_off,
    output logic [7:0]        slice_adj,
    output logic [1:0]        xpt_range,
    output logic [3:0]        deemph_code,
    output logic [2:0]        swing_code,
    output logic              rx_tune_en,
    output logic [1:0]        rx_tune,
    output logic              in_bias_boost,
    output logic              los_lvl_prog,
    output logic [6:0]        los_lvl_code,
    output logic              fmask_en,
    output logic [6:0]        fmask_time,
    output logic              rmask_en,
    output logic [6:0]        rmask_time
);

    logic [2:0]            sync_out;
    logic                  scl_s, sda_s, dis_s;
    logic                  ser_locked;
    logic [7:0]            ptr, wr_data, rdata;
    logic                  wr_en, start_evt, stop_evt;
    logic [NUM_REGS*8-1:0] regs_flat;

    cfg_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dis_pin_i, sda_i, scl_i}),
        .q     (sync_out)
    );

    assign scl_s = sync_out[0];
    assign sda_s = sync_out[1];
    assign dis_s = sync_out[2];

    assign ser_locked = ser_lock_en & dis_s;

    cfg_bus_engine #(
        .DEV_ADDR (DEV_ADDR)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .lock      (ser_locked),
        .rdata     (rdata),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    cfg_regfile #(
        .NUM_REGS    (NUM_REGS),
        .STATUS_ADDR (STATUS_ADDR),
        .STAT_W      (STAT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (ptr),
        .wr_data   (wr_data),
        .status    (los_status_i),
        .rdata     (rdata),
        .regs_flat (regs_flat)
    );

    // field decode
    assign ser_lock_en     = regs_flat[REG_CTRL*8 + 5];
    assign out_invert      = regs_flat[REG_CTRL*8 + 4];
    assign out_mute        = regs_flat[REG_CTRL*8 + 3];
    assign los_rng_hi      = regs_flat[REG_CTRL*8 + 2];
    assign offs_cancel_off = regs_flat[REG_CTRL*8 + 1];
    assign slice_adj       = regs_flat[REG_SLICE*8 +: 8];
    assign xpt_range       = regs_flat[REG_XPDE*8 + 4 +: 2];
    assign deemph_code     = regs_flat[REG_XPDE*8 +: 4];
    assign swing_code      = regs_flat[REG_SWING*8 +: 3];
    assign rx_tune_en      = regs_flat[REG_TUNE*8 + 7];
    assign rx_tune         = regs_flat[REG_TUNE*8 + 2 +: 2];
    assign in_bias_boost   = regs_flat[REG_TUNE*8];
    assign los_lvl_prog    = regs_flat[REG_LOSL*8 + 7];
    assign los_lvl_code    = regs_flat[REG_LOSL*8 +: 7];
    assign fmask_en        = regs_flat[REG_FMASK*8 + 7];
    assign fmask_time      = regs_flat[REG_FMASK*8 +: 7];
    assign rmask_en        = regs_flat[REG_RMASK*8 + 7];
    assign rmask_time      = regs_flat[REG_RMASK*8 +: 7];

endmodule

// File: rtl/cfg_twowire_slave_chk.sv
module cfg_twowire_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_s,
    input logic lock,
    input logic wr_en,
    input logic start_evt,
    input logic stop_evt
);

    logic [1:0] wr_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt_q <= '0;
        end else if (start_evt) begin
            wr_cnt_q <= '0;
        end else if (wr_en && wr_cnt_q != 2'd3) begin
            wr_cnt_q <= wr_cnt_q + 2'd1;
        end
    end

    AST_SDA_MOVES_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !lock) |-> !scl_s) else $error("sda_oe moved with clock high"); // R8

    AST_ONE_WRITE_PER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_cnt_q == 2'd0)) else $error("second write in one transaction"); // R5

    AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> !wr_en) else $error("write while locked"); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe) else $error("line held after stop"); // R9

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe) else $error("line held after start"); // R9

endmodule

bind cfg_twowire_slave cfg_twowire_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .lock      (ser_locked),
    .wr_en     (wr_en),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
);

// File: tb/tb_cfg_twowire_slave.sv
module tb_cfg_twowire_slave;

    localparam int         Q   = 8;
    localparam logic [6:0] DEV = 7'h44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       dis_pin = 1'b0;
    logic [6:0] stat_in = 7'h35;

    logic       sda_oe;
    logic       sda_bus;
    logic ser_lock_en, out_invert, out_mute, los_rng_hi, offs_cancel_off;
    logic [7:0] slice_adj;
    logic [1:0] xpt_range;
    logic [3:0] deemph_code;
    logic [2:0] swing_code;
    logic       rx_tune_en;
    logic [1:0] rx_tune;
    logic       in_bias_boost, los_lvl_prog, fmask_en, rmask_en;
    logic [6:0] los_lvl_code, fmask_time, rmask_time;
    logic [49:0] act_vec;

    assign sda_bus = m_sda & ~sda_oe;

    cfg_twowire_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .dis_pin_i(dis_pin), .los_status_i(stat_in),
        .ser_lock_en(ser_lock_en), .out_invert(out_invert), .out_mute(out_mute),
        .los_rng_hi(los_rng_hi), .offs_cancel_off(offs_cancel_off), .slice_adj(slice_adj),
        .xpt_range(xpt_range), .deemph_code(deemph_code), .swing_code(swing_code),
        .rx_tune_en(rx_tune_en), .rx_tune(rx_tune), .in_bias_boost(in_bias_boost),
        .los_lvl_prog(los_lvl_prog), .los_lvl_code(los_lvl_code),
        .fmask_en(fmask_en), .fmask_time(fmask_time), .rmask_en(rmask_en), .rmask_time(rmask_time)
    );

    assign act_vec = {ser_lock_en, out_invert, out_mute, los_rng_hi, offs_cancel_off,
                      slice_adj, xpt_range, deemph_code, swing_code,
                      rx_tune_en, rx_tune, in_bias_boost,
                      los_lvl_prog, los_lvl_code, fmask_en, fmask_time, rmask_en, rmask_time};

    int   n_vec = 0;
    int   n_bad = 0;
    bit   cmp_en = 0;
    bit   done = 0;
    logic [7:0] mdl [0:15];
    logic prev_oe = 1'b0;

    function automatic logic [49:0] exp_vec();
        return {mdl[0][5], mdl[0][4], mdl[0][3], mdl[0][2], mdl[0][1],
                mdl[1], mdl[2][5:4], mdl[2][3:0], mdl[3][2:0],
                mdl[7][7], mdl[7][3:2], mdl[7][0],
                mdl[11], mdl[12], mdl[13]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every idle clock: fields follow the model, line released (R11, R9)
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R11 per-cycle fields", 64'(act_vec), 64'(exp_vec()));
            chk("R9 idle line released", 64'(sda_oe), 64'd0);
        end
    end

    // R8: the slave's drive never moves while the master holds the clock high
    always @(negedge clk) begin
        if (rst_n && !done && sda_oe !== prev_oe) begin
            chk("R8 drive change with clock low", 64'(m_scl), 64'd0);
        end
        prev_oe = sda_oe;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        b = sda_bus; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = (b == 1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!mack);
    endtask

    task automatic wr_xfer(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                           output logic [2:0] acks);
        bit a0, a1, a2;
        cmp_en = 0;
        bus_start();
        send_byte({dev, 1'b0}, a0);
        send_byte(ra, a1);
        send_byte(d, a2);
        bus_stop();
        acks = {a0, a1, a2};
    endtask

    task automatic do_write(input logic [7:0] ra, input logic [7:0] d, input string req);
        logic [2:0] acks;
        wr_xfer(DEV, ra, d, acks);
        chk({req, " acks"}, 64'(acks), 64'h7);
        if (ra < 8'd14) mdl[ra[3:0]] = d;
        cmp_en = 1;
        wq(4);
        chk({req, " fields"}, 64'(act_vec), 64'(exp_vec()));
    endtask

    task automatic do_read(input logic [7:0] ra, input logic [7:0] expd, input string req);
        bit a0, a1, a2;
        logic [7:0] d;
        cmp_en = 0;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(ra, a1);
        bus_start();
        send_byte({DEV, 1'b1}, a2);
        recv_byte(d, 1'b0);
        bus_stop();
        chk({req, " acks"}, 64'({a0, a1, a2}), 64'h7);
        chk({req, " data"}, 64'(d), 64'(expd));
        cmp_en = 1;
        wq(4);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [2:0] acks;
        bit a0, a1, a2, a3;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        mdl[3] = 8'h02;

        wq(5);
        rst_n = 1'b1;
        wq(6);
        // R1: reset values
        chk("R1 reset fields", 64'(act_vec), 64'(exp_vec()));
        chk("R1 reset swing", 64'(swing_code), 64'd2);
        chk("R1 reset line", 64'(sda_oe), 64'd0);
        cmp_en = 1;
        wq(10);
        do_read(8'h03, 8'h02, "R1 reset readback");

        // R2 / R11: writes to each decoded register
        do_write(8'h00, 8'h1E, "R2 ctrl");
        do_write(8'h01, 8'hA5, "R2 slice");
        do_write(8'h02, 8'h3B, "R11 xpt/deemph");
        do_write(8'h03, 8'h07, "R11 swing");
        do_write(8'h07, 8'h8D, "R11 tune");
        do_write(8'h0B, 8'hC2, "R11 los level");
        do_write(8'h0C, 8'h91, "R11 fall mask");
        do_write(8'h0D, 8'h7F, "R11 rise mask");
        do_write(8'h04, 8'h5A, "R2 plain reg");

        // R4: readback, MSB first
        do_read(8'h01, 8'hA5, "R4 read slice");
        do_read(8'h02, 8'h3B, "R4 read xpde");
        do_read(8'h04, 8'h5A, "R4 read plain");
        do_read(8'h0D, 8'h7F, "R4 read rmask");

        // R6: status location
        do_read(8'h0F, {1'b0, stat_in}, "R6 status");
        stat_in = 7'h4A;
        wq(4);
        do_read(8'h0F, 8'h4A, "R6 status changed");
        do_write(8'h0F, 8'hFF, "R6 status write");
        do_read(8'h0F, 8'h4A, "R6 status after write");

        // R7: unimplemented addresses
        do_write(8'h0E, 8'h77, "R7 write 0x0E");
        do_read(8'h0E, 8'h00, "R7 read 0x0E");
        do_write(8'h80, 8'h66, "R7 write 0x80");
        do_read(8'h80, 8'h00, "R7 read 0x80");

        // R3: foreign addresses
        wr_xfer(7'h45, 8'h01, 8'h00, acks);
        chk("R3 addr 0x45 no ack", 64'(acks), 64'h0);
        cmp_en = 1; wq(4);
        wr_xfer(7'h04, 8'h01, 8'h00, acks);
        chk("R3 addr 0x04 no ack", 64'(acks), 64'h0);
        cmp_en = 1; wq(4);
        chk("R3 no change", 64'(act_vec), 64'(exp_vec()));
        do_read(8'h01, 8'hA5, "R3 slice kept");

        // R5: second data byte refused
        cmp_en = 0;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h01, a1);
        send_byte(8'h11, a2);
        send_byte(8'h22, a3);
        bus_stop();
        chk("R5 acks then nack", 64'({a0, a1, a2, a3}), 64'hE);
        mdl[1] = 8'h11;
        cmp_en = 1; wq(4);
        chk("R5 first byte kept", 64'(slice_adj), 64'h11);
        do_read(8'h01, 8'h11, "R5 readback");
        do_read(8'h02, 8'h3B, "R5 no pointer advance");

        // R9: stop before data, then start in mid byte
        cmp_en = 0;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h02, a1);
        bus_stop();
        cmp_en = 1; wq(4);
        chk("R9 stop before data", 64'(act_vec), 64'(exp_vec()));
        cmp_en = 0;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h03, a1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h0C, a1);
        send_byte(8'h05, a2);
        bus_stop();
        chk("R9 restart acks", 64'({a0, a1, a2}), 64'h7);
        mdl[12] = 8'h05;
        cmp_en = 1; wq(4);
        chk("R9 aborted byte dropped", 64'(swing_code), 64'd7);
        chk("R9 restarted write", 64'(fmask_time), 64'd5);

        // R10: lock through the control bit and the pin
        dis_pin = 1'b1;
        wq(8);
        wr_xfer(DEV, 8'h00, 8'h20, acks);
        chk("R10 lock byte ack cut", 64'(acks), 64'h6);
        mdl[0] = 8'h20;
        cmp_en = 1; wq(4);
        chk("R10 lock enable set", 64'(ser_lock_en), 64'd1);
        wr_xfer(DEV, 8'h01, 8'h99, acks);
        chk("R10 locked no ack", 64'(acks), 64'h0);
        cmp_en = 1; wq(4);
        chk("R10 locked no write", 64'(slice_adj), 64'h11);
        dis_pin = 1'b0;
        wq(8);
        do_write(8'h01, 8'h99, "R10 unlocked write");
        do_write(8'h00, 8'h00, "R10 clear lock");
        do_read(8'h01, 8'h99, "R10 unlocked read");

        wq(20);
        finish_run();
    end

endmodule